// File: doc/BRIEF.md
# Host Adapter Command Register Window

This block is the adapter side of a small byte-wide register window that a host processor uses to configure a disk-bus host adapter. Three offsets are decoded. Each offset has a different meaning for reads and for writes. Offset 0 takes control writes (resets and interrupt acknowledge) and returns the status byte. Offset 1 takes opcode and parameter bytes and returns reply bytes. Offset 2 returns the interrupt byte.

A command is one opcode byte followed by a fixed number of parameter bytes. A table inside the block gives, for each opcode, how many parameter bytes follow and how many reply bytes come back. Reply bytes are taken from a configuration byte vector supplied on an input port. The host paces itself with three status flags: busy, data-in ready and adapter ready. The two mailbox-initialise opcodes latch a mailbox count and base address on output ports. A start-mailbox opcode produces a one-cycle strobe for the mailbox engine, which sits outside this block. A completed command raises the command-complete interrupt. An unknown opcode locks the command path until a hard reset.

Top module: `host_cmd_window`

## Requirements
- R1: Reads are side-effect free except at offset 1. Offset 0 returns the status byte {diagActive, 0, initRequired, ready, busy, dataInReady, 0, cmdInvalid} (bit 7 down to bit 0). Offset 1 returns the data-in byte. Offset 2 returns the interrupt byte {valid, 0, 0, 0, busResetSeen, cmdComplete, 0, 0}. Offset 3 returns 0. After rst_n the status reads 0x30 and the interrupt byte reads 0x00.
- R2: Writing a control byte with bit 7 set is a hard reset. It clears the mailbox count, base, extended and wide outputs, the invalid lockout and the interrupt byte. The status then reads 0xA0 for DIAG_CYCLES cycles and exactly 0x30 afterwards.
- R3: Each byte accepted at offset 1 sets busy (status 0x08) for exactly the next cycle. A parameter byte written while busy is set is dropped.
- R4: Opcode 0x01 takes 4 parameters: a count, then a 24-bit base address, most significant byte first. On completion mbxCount holds the count, mbxBase holds the address with its upper byte zero, extMode is 0 and init-required clears.
- R5: Opcode 0x81 takes 5 parameters: a count, then a 32-bit base address, least significant byte first. On completion mbxCount and mbxBase are loaded, extMode is 1 and init-required clears.
- R6: Opcode 0x04 returns configuration bytes 0..3 and opcode 0x0B returns bytes 4..6, in that order. Data-in ready (status 0x04) is set while a reply byte waits and is clear in the cycle after that byte is read at offset 1.
- R7: Opcode 0x8D takes one parameter N and returns N bytes, byte k being configuration byte (8+k) mod CFG_BYTES. With N = 0 the command completes with no reply.
- R8: Opcode 0x96 takes one parameter, and bit 0 of that parameter becomes wideMode on completion.
- R9: Once all parameters are in and all reply bytes are read, the interrupt byte reads 0x84, irq is high and ready (status 0x10) returns.
- R10: Opcode 0x02 is accepted whenever no command is in progress and busy is clear, even while ready is low. It pulses mbxStart for one cycle and leaves the interrupt byte unchanged.
- R11: Any opcode outside {0x01, 0x02, 0x04, 0x0B, 0x81, 0x8D, 0x96} sets cmdInvalid (status 0x01) and command-complete (interrupt 0x84). Ready then stays low and all other opcodes are ignored until a hard reset.
- R12: Control bit 5 clears the interrupt byte. Control bit 4 pulses scsiBusReset for one cycle and sets busResetSeen (interrupt 0x88). When both bits are written together, the set wins.
- R13: Control bit 6 (soft reset) aborts any command in progress, clears data-in ready and the interrupt byte, and returns to ready. It keeps the mailbox outputs, init-required and the invalid lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe (consumes a data-in byte at offset 1) |
| addr | input | 2 | Register offset |
| wrData | input | 8 | Host write byte |
| rdData | output | 8 | Host read byte for the current offset |
| cfgBytes | input | CFG_BYTES*8 | Configuration bytes used for replies, byte i at bits 8i+7..8i |
| irq | output | 1 | Interrupt request, equal to the valid bit |
| mbxStart | output | 1 | One-cycle strobe on an accepted start-mailbox opcode |
| scsiBusReset | output | 1 | One-cycle strobe on a bus-reset control write |
| mbxCount | output | 8 | Latched mailbox count |
| mbxBase | output | 32 | Latched mailbox base address |
| extMode | output | 1 | 1 when the last mailbox init used 32-bit addressing |
| wideMode | output | 1 | Wide transfer enable from opcode 0x96 |

## Verification
The bench sweeps every one of the 256 opcode values. Each unknown value must lock the command path with status 0x21 and interrupt 0x84, and each known value must not. Mailbox-init address vectors with distinct bytes in every position show whether the 0x01 command assembles its address most-significant-byte first and the 0x81 command least-significant-byte first. The 0x8D reply length runs from 0 to 20 against a configuration vector of 16 distinct bytes, which exposes both the reply index wrap and the empty-reply completion. Back-to-back parameter writes, resets issued in the middle of a command, and combined control bits separate the busy-drop rule, the soft-reset versus hard-reset scopes and the set-over-clear order in the interrupt byte.

// File: rtl/hcw_pkg.sv
package hcw_pkg;

  localparam logic [7:0] OP_MBX_INIT  = 8'h01;
  localparam logic [7:0] OP_MBX_START = 8'h02;
  localparam logic [7:0] OP_INQUIRY   = 8'h04;
  localparam logic [7:0] OP_CONFIG    = 8'h0B;
  localparam logic [7:0] OP_XINIT     = 8'h81;
  localparam logic [7:0] OP_XSETUP    = 8'h8D;
  localparam logic [7:0] OP_WIDE      = 8'h96;

  typedef enum logic [1:0] {CK_NONE, CK_INIT24, CK_INIT32, CK_WIDE} commitKind_t;

  typedef struct packed {
    logic        known;
    logic [2:0]  nParams;
    logic [2:0]  nReply;
    logic        replyFromParam;
    logic        lsbFirst;
    commitKind_t kind;
    logic [7:0]  replyBase;
  } opInfo_t;

  // strobes from control to datapath
  typedef struct packed {
    logic        paramWr;
    logic        firstParam;
    logic        lsbFirst;
    logic        commit;
    commitKind_t kind;
    logic        cfgClear;
    logic        loadReply;
    logic [7:0]  replyOffset;
  } dpStrobe_t;

  function automatic opInfo_t opLookup(input logic [7:0] op);
    opInfo_t r;
    r = '0;
    r.kind = CK_NONE;
    case (op)
      OP_MBX_INIT:  begin r.known = 1'b1; r.nParams = 3'd4; r.kind = CK_INIT24; end
      OP_MBX_START: begin r.known = 1'b1; end
      OP_INQUIRY:   begin r.known = 1'b1; r.nReply = 3'd4; r.replyBase = 8'd0; end
      OP_CONFIG:    begin r.known = 1'b1; r.nReply = 3'd3; r.replyBase = 8'd4; end
      OP_XINIT:     begin r.known = 1'b1; r.nParams = 3'd5; r.lsbFirst = 1'b1; r.kind = CK_INIT32; end
      OP_XSETUP:    begin r.known = 1'b1; r.nParams = 3'd1; r.replyFromParam = 1'b1; r.replyBase = 8'd8; end
      OP_WIDE:      begin r.known = 1'b1; r.nParams = 3'd1; r.kind = CK_WIDE; end
      default:      r.known = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/hcw_ctrl.sv
module hcw_ctrl
  import hcw_pkg::*;
#(
  parameter int DIAG_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output dpStrobe_t  strobe,
  output logic [7:0] statusByte,
  output logic [7:0] intrByte,
  output logic       irq,
  output logic       mbxStart,
  output logic       scsiBusReset
);
  localparam int DCW = $clog2(DIAG_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_PARAM, S_REPLY, S_FINISH} state_t;

  state_t      state;
  logic        busyQ, dirRdyQ, lockoutQ, initReqQ, intCmdcQ, intBusRstQ;
  logic        mbxStartQ, busRstQ;
  logic [DCW-1:0] diagCnt;
  logic [2:0]  paramCnt, paramTotal;
  logic [7:0]  replyCnt, replyLen, curBase;
  logic        curLsb, curFromParam;
  commitKind_t curKind;

  logic ctrlWr, cmdWr, dataRd, hardRst, softRst, intRst, busRst;
  logic diagActive, readyFlag, startAccept, normalAccept, paramAccept, lastParam;
  logic [7:0] nextReplyLen;
  opInfo_t info;

  assign ctrlWr  = wrEn && (addr == 2'd0);
  assign cmdWr   = wrEn && (addr == 2'd1);
  assign dataRd  = rdEn && (addr == 2'd1);
  assign hardRst = ctrlWr && wrData[7];
  assign softRst = ctrlWr && wrData[6];
  assign intRst  = ctrlWr && wrData[5];
  assign busRst  = ctrlWr && wrData[4];

  assign info         = opLookup(wrData);
  assign diagActive   = (diagCnt != '0);
  assign readyFlag    = (state == S_IDLE) && !busyQ && !diagActive && !lockoutQ;
  assign startAccept  = cmdWr && (state == S_IDLE) && !busyQ && (wrData == OP_MBX_START);
  assign normalAccept = cmdWr && readyFlag && (wrData != OP_MBX_START);
  assign paramAccept  = cmdWr && (state == S_PARAM) && !busyQ;
  assign lastParam    = (paramCnt + 3'd1 == paramTotal);
  assign nextReplyLen = curFromParam ? wrData : replyLen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; busyQ <= 1'b0; dirRdyQ <= 1'b0; lockoutQ <= 1'b0;
      initReqQ <= 1'b1; intCmdcQ <= 1'b0; intBusRstQ <= 1'b0;
      mbxStartQ <= 1'b0; busRstQ <= 1'b0; diagCnt <= '0;
      paramCnt <= '0; paramTotal <= '0; replyCnt <= '0; replyLen <= '0;
      curBase <= '0; curLsb <= 1'b0; curFromParam <= 1'b0; curKind <= CK_NONE;
    end else if (hardRst) begin
      state <= S_IDLE; busyQ <= 1'b0; dirRdyQ <= 1'b0; lockoutQ <= 1'b0;
      initReqQ <= 1'b1; intCmdcQ <= 1'b0; intBusRstQ <= busRst;
      mbxStartQ <= 1'b0; busRstQ <= busRst; diagCnt <= DCW'(DIAG_CYCLES);
    end else begin
      mbxStartQ <= startAccept;
      busRstQ   <= busRst;
      busyQ     <= 1'b0;
      if (diagActive) diagCnt <= diagCnt - DCW'(1);
      if (intRst) begin intCmdcQ <= 1'b0; intBusRstQ <= 1'b0; end
      if (softRst) begin
        state <= S_IDLE; dirRdyQ <= 1'b0; intCmdcQ <= 1'b0; intBusRstQ <= 1'b0;
      end else begin
        case (state)
          S_IDLE: begin
            if (startAccept) busyQ <= 1'b1;
            else if (normalAccept) begin
              busyQ <= 1'b1;
              if (!info.known) begin
                lockoutQ <= 1'b1;
                intCmdcQ <= 1'b1;
              end else begin
                curKind <= info.kind; curLsb <= info.lsbFirst;
                curBase <= info.replyBase; curFromParam <= info.replyFromParam;
                paramTotal <= info.nParams; paramCnt <= '0;
                replyLen <= {5'd0, info.nReply}; replyCnt <= '0;
                if (info.nParams != 3'd0) state <= S_PARAM;
                else if (info.nReply != 3'd0) state <= S_REPLY;
                else state <= S_FINISH;
              end
            end
          end
          S_PARAM: if (paramAccept) begin
            busyQ    <= 1'b1;
            paramCnt <= paramCnt + 3'd1;
            replyLen <= nextReplyLen;
            if (lastParam) state <= (nextReplyLen != 8'd0) ? S_REPLY : S_FINISH;
          end
          S_REPLY: begin
            if (!dirRdyQ) begin
              dirRdyQ  <= 1'b1;
              replyCnt <= replyCnt + 8'd1;
            end else if (dataRd) begin
              dirRdyQ <= 1'b0;
              if (replyCnt == replyLen) state <= S_FINISH;
            end
          end
          S_FINISH: begin
            intCmdcQ <= 1'b1;
            if (curKind == CK_INIT24 || curKind == CK_INIT32) initReqQ <= 1'b0;
            state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
      if (busRst) intBusRstQ <= 1'b1;
    end
  end

  always_comb begin
    strobe.paramWr     = paramAccept && !hardRst && !softRst;
    strobe.firstParam  = (paramCnt == 3'd0);
    strobe.lsbFirst    = curLsb;
    strobe.commit      = (state == S_FINISH) && !hardRst && !softRst;
    strobe.kind        = curKind;
    strobe.cfgClear    = hardRst;
    strobe.loadReply   = (state == S_REPLY) && !dirRdyQ && !hardRst && !softRst;
    strobe.replyOffset = curBase + replyCnt;
  end

  assign statusByte   = {diagActive, 1'b0, initReqQ, readyFlag, busyQ, dirRdyQ, 1'b0, lockoutQ};
  assign intrByte     = {intBusRstQ | intCmdcQ, 3'b000, intBusRstQ, intCmdcQ, 2'b00};
  assign irq          = intrByte[7];
  assign mbxStart     = mbxStartQ;
  assign scsiBusReset = busRstQ;

  // R3: busy never lasts two cycles
  assert_busy_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busyQ |=> !busyQ);
  // R6: a consumed reply byte drops data-in ready
  assert_dirrdy_consumed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dataRd && dirRdyQ) |=> !dirRdyQ);
  // R11: lockout only leaves through hard reset
  assert_lockout_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lockoutQ && !hardRst) |=> lockoutQ);
  // R10: start-mailbox raises no completion
  assert_start_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (startAccept && !hardRst) |=> !$rose(intCmdcQ));
  // R9: the finish step always posts completion
  assert_finish_complete_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FINISH && !hardRst && !softRst) |=> (intCmdcQ && state == S_IDLE));

endmodule

// File: rtl/hcw_datapath.sv
module hcw_datapath
  import hcw_pkg::*;
#(
  parameter int CFG_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  dpStrobe_t              strobe,
  input  logic [7:0]             wrData,
  input  logic [CFG_BYTES*8-1:0] cfgBytes,
  input  logic [1:0]             addr,
  input  logic [7:0]             statusByte,
  input  logic [7:0]             intrByte,
  output logic [7:0]             rdData,
  output logic [7:0]             mbxCount,
  output logic [31:0]            mbxBase,
  output logic                   extMode,
  output logic                   wideMode
);
  logic [7:0]  stageCount, dataInQ, replySel, wrapIdx;
  logic [31:0] stageAddr;

  assign wrapIdx = strobe.replyOffset % 8'(CFG_BYTES);

  always_comb begin
    replySel = 8'h00;
    for (int i = 0; i < CFG_BYTES; i++)
      if (int'(wrapIdx) == i) replySel = cfgBytes[i*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stageCount <= '0; stageAddr <= '0; dataInQ <= '0;
      mbxCount <= '0; mbxBase <= '0; extMode <= 1'b0; wideMode <= 1'b0;
    end else if (strobe.cfgClear) begin
      mbxCount <= '0; mbxBase <= '0; extMode <= 1'b0; wideMode <= 1'b0;
    end else begin
      if (strobe.paramWr) begin
        if (strobe.firstParam)   stageCount <= wrData;
        else if (strobe.lsbFirst) stageAddr <= {wrData, stageAddr[31:8]};
        else                      stageAddr <= {stageAddr[23:0], wrData};
      end
      if (strobe.commit) begin
        case (strobe.kind)
          CK_INIT24: begin mbxCount <= stageCount; mbxBase <= {8'h00, stageAddr[23:0]}; extMode <= 1'b0; end
          CK_INIT32: begin mbxCount <= stageCount; mbxBase <= stageAddr; extMode <= 1'b1; end
          CK_WIDE:   wideMode <= stageCount[0];
          default:   ;
        endcase
      end
      if (strobe.loadReply) dataInQ <= replySel;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdData = statusByte;
      2'd1:    rdData = dataInQ;
      2'd2:    rdData = intrByte;
      default: rdData = 8'h00;
    endcase
  end

  // R4: a 24-bit init never leaves upper address bits set
  assert_init24_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.commit && !strobe.cfgClear && strobe.kind == CK_INIT24) |=> (mbxBase[31:24] == 8'h00 && !extMode));
  // R2: hard reset empties the mailbox configuration
  assert_hard_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.cfgClear |=> (mbxCount == 8'h00 && mbxBase == 32'h0 && !extMode && !wideMode));

endmodule

// File: rtl/host_cmd_window.sv
module host_cmd_window
  import hcw_pkg::*;
#(
  parameter int CFG_BYTES   = 16,
  parameter int DIAG_CYCLES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic [1:0]             addr,
  input  logic [7:0]             wrData,
  output logic [7:0]             rdData,
  input  logic [CFG_BYTES*8-1:0] cfgBytes,
  output logic                   irq,
  output logic                   mbxStart,
  output logic                   scsiBusReset,
  output logic [7:0]             mbxCount,
  output logic [31:0]            mbxBase,
  output logic                   extMode,
  output logic                   wideMode
);
  dpStrobe_t  strobe;
  logic [7:0] statusByte, intrByte;

  hcw_ctrl #(.DIAG_CYCLES(DIAG_CYCLES)) uCtrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .strobe(strobe), .statusByte(statusByte),
    .intrByte(intrByte), .irq(irq), .mbxStart(mbxStart),
    .scsiBusReset(scsiBusReset)
  );

  hcw_datapath #(.CFG_BYTES(CFG_BYTES)) uData (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(wrData),
    .cfgBytes(cfgBytes), .addr(addr), .statusByte(statusByte),
    .intrByte(intrByte), .rdData(rdData), .mbxCount(mbxCount),
    .mbxBase(mbxBase), .extMode(extMode), .wideMode(wideMode)
  );

endmodule

// File: tb/tb_host_cmd_window.sv
`timescale 1ns/1ps
module tb_host_cmd_window;
  localparam int CFG_BYTES = 16;
  localparam int DIAG = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [CFG_BYTES*8-1:0] cfgBytes;
  logic irq, mbxStart, scsiBusReset, extMode, wideMode;
  logic [7:0] mbxCount;
  logic [31:0] mbxBase;

  int vectors = 0;
  int errs = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  host_cmd_window #(.CFG_BYTES(CFG_BYTES), .DIAG_CYCLES(DIAG)) dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .cfgBytes(cfgBytes), .irq(irq),
    .mbxStart(mbxStart), .scsiBusReset(scsiBusReset), .mbxCount(mbxCount),
    .mbxBase(mbxBase), .extMode(extMode), .wideMode(wideMode)
  );

  function automatic logic [7:0] cfgVal(input int i);
    return 8'(8'h30 + 7 * i);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] d);
    hostWrite(2'd1, d);
    idle(1);
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    addr = a; #0.5; v = rdData;
  endtask

  task automatic readData(output logic [7:0] v);
    addr = 2'd1; rdEn = 1'b1; #0.5; v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitStatusBit(input int b, input string tag);
    logic [7:0] s;
    int n;
    n = 0;
    peek(2'd0, s);
    while (!s[b] && n < 60) begin
      idle(1); n++; peek(2'd0, s);
    end
    if (!s[b]) chk(tag, {24'h0, s}, 32'hFFFF_FFFF);
  endtask

  task automatic hardReset();
    hostWrite(2'd0, 8'h80);
    idle(DIAG);
  endtask

  // reads N reply bytes and checks them against a base index
  task automatic readReply(input int n, input int base, input string tag);
    logic [7:0] v, s;
    for (int k = 0; k < n; k++) begin
      waitStatusBit(2, tag);
      readData(v);
      chk(tag, {24'h0, v}, {24'h0, cfgVal((base + k) % CFG_BYTES)});
      peek(2'd0, s);
      chk({tag, " dirRdy cleared"}, {31'h0, s[2]}, 32'h0);
    end
  endtask

  initial begin
    logic [7:0] s, v;
    logic [31:0] a32;
    logic [7:0] cnt;
    for (int i = 0; i < CFG_BYTES; i++) cfgBytes[i*8 +: 8] = cfgVal(i);
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state and read map
    peek(2'd0, s); chk("R1 status after reset", {24'h0, s}, 32'h30);
    peek(2'd2, s); chk("R1 intr after reset", {24'h0, s}, 32'h00);
    peek(2'd3, s); chk("R1 offset 3 reads zero", {24'h0, s}, 32'h00);
    chk("R1 irq low", {31'h0, irq}, 32'h0);

    // R3 busy for one cycle, parameter dropped while busy; R4 init
    hostWrite(2'd1, 8'h01);
    peek(2'd0, s); chk("R3 busy after opcode", {24'h0, s}, 32'h28);
    idle(1);
    peek(2'd0, s); chk("R3 busy gone", {24'h0, s}, 32'h20);
    hostWrite(2'd1, 8'h10);
    hostWrite(2'd1, 8'hEE);          // lands while busy: dropped
    idle(1);
    sendByte(8'hAB); sendByte(8'hCD); sendByte(8'hEF);
    waitStatusBit(4, "R9 ready after init");
    chk("R3 dropped byte ignored count", {24'h0, mbxCount}, 32'h10);
    chk("R4 base msb first", mbxBase, 32'h00AB_CDEF);
    peek(2'd0, s); chk("R4 init-required cleared", {24'h0, s}, 32'h10);
    peek(2'd2, s); chk("R9 complete intr", {24'h0, s}, 32'h84);
    chk("R9 irq", {31'h0, irq}, 32'h1);
    hostWrite(2'd0, 8'h20);
    peek(2'd2, s); chk("R12 intr cleared", {24'h0, s}, 32'h00);

    // R4 sweep of 24-bit init
    for (int i = 0; i < 8; i++) begin
      cnt = 8'(8 * (i + 1));
      a32 = (32'(i) * 32'h0012_3457 + 32'h0001_0203) & 32'h00FF_FFFF;
      sendByte(8'h01); sendByte(cnt);
      sendByte(a32[23:16]); sendByte(a32[15:8]); sendByte(a32[7:0]);
      waitStatusBit(4, "R4 ready");
      chk("R4 count", {24'h0, mbxCount}, {24'h0, cnt});
      chk("R4 base", mbxBase, a32);
      chk("R4 ext mode off", {31'h0, extMode}, 32'h0);
      hostWrite(2'd0, 8'h20);
    end

    // R5 sweep of 32-bit init
    for (int i = 0; i < 8; i++) begin
      cnt = 8'(4 * i + 3);
      a32 = 32'(i) * 32'h1357_9BDF + 32'h0403_0201;
      sendByte(8'h81); sendByte(cnt);
      sendByte(a32[7:0]); sendByte(a32[15:8]); sendByte(a32[23:16]); sendByte(a32[31:24]);
      waitStatusBit(4, "R5 ready");
      chk("R5 count", {24'h0, mbxCount}, {24'h0, cnt});
      chk("R5 base lsb first", mbxBase, a32);
      chk("R5 ext mode on", {31'h0, extMode}, 32'h1);
      peek(2'd2, s); chk("R9 intr after ext init", {24'h0, s}, 32'h84);
      hostWrite(2'd0, 8'h20);
    end

    // R6 inquiry replies
    sendByte(8'h04);
    readReply(4, 0, "R6 inquiry byte");
    waitStatusBit(4, "R9 ready after inquiry");
    peek(2'd2, s); chk("R9 intr after reply", {24'h0, s}, 32'h84);
    hostWrite(2'd0, 8'h20);
    sendByte(8'h0B);
    readReply(3, 4, "R6 config byte");
    waitStatusBit(4, "R9 ready after config");
    hostWrite(2'd0, 8'h20);

    // R7 setup-information reply sweep including wrap and empty reply
    for (int n = 0; n <= 20; n++) begin
      sendByte(8'h8D); sendByte(8'(n));
      readReply(n, 8, "R7 setup byte");
      waitStatusBit(4, "R7 ready");
      peek(2'd2, s); chk("R7 complete", {24'h0, s}, 32'h84);
      hostWrite(2'd0, 8'h20);
    end

    // R8 wide enable
    sendByte(8'h96); sendByte(8'h01); waitStatusBit(4, "R8 ready");
    chk("R8 wide on", {31'h0, wideMode}, 32'h1);
    sendByte(8'h96); sendByte(8'hFE); waitStatusBit(4, "R8 ready");
    chk("R8 wide off", {31'h0, wideMode}, 32'h0);
    sendByte(8'h96); sendByte(8'h03); waitStatusBit(4, "R8 ready");
    chk("R8 wide on again", {31'h0, wideMode}, 32'h1);
    hostWrite(2'd0, 8'h20);

    // R10 start mailbox while ready
    hostWrite(2'd1, 8'h02);
    chk("R10 start pulse", {31'h0, mbxStart}, 32'h1);
    idle(1);
    chk("R10 pulse one cycle", {31'h0, mbxStart}, 32'h0);
    peek(2'd2, s); chk("R10 no complete", {24'h0, s}, 32'h00);
    peek(2'd0, s); chk("R10 ready again", {24'h0, s}, 32'h10);

    // R12 bus reset and interrupt clear ordering
    hostWrite(2'd0, 8'h10);
    chk("R12 bus reset pulse", {31'h0, scsiBusReset}, 32'h1);
    peek(2'd2, s); chk("R12 bus reset intr", {24'h0, s}, 32'h88);
    idle(1);
    chk("R12 pulse one cycle", {31'h0, scsiBusReset}, 32'h0);
    hostWrite(2'd0, 8'h20);
    peek(2'd2, s); chk("R12 clear", {24'h0, s}, 32'h00);
    hostWrite(2'd0, 8'h30);
    peek(2'd2, s); chk("R12 set wins", {24'h0, s}, 32'h88);
    hostWrite(2'd0, 8'h20);

    // R13 soft reset mid-command keeps configuration
    sendByte(8'h81); sendByte(8'h55); sendByte(8'h99);
    hostWrite(2'd0, 8'h40);
    idle(1);
    peek(2'd0, s); chk("R13 ready after soft", {24'h0, s}, 32'h10);
    chk("R13 count kept", {24'h0, mbxCount}, {24'h0, 8'(4 * 7 + 3)});
    chk("R13 ext kept", {31'h0, extMode}, 32'h1);
    sendByte(8'h04);
    waitStatusBit(2, "R13 reply pending");
    hostWrite(2'd0, 8'h40);
    peek(2'd0, s); chk("R13 reply aborted", {24'h0, s}, 32'h10);
    peek(2'd2, s); chk("R13 intr cleared", {24'h0, s}, 32'h00);

    // R2 hard reset with diagnostic window
    hostWrite(2'd0, 8'h80);
    for (int k = 0; k < DIAG; k++) begin
      peek(2'd0, s); chk("R2 diag status", {24'h0, s}, 32'hA0);
      idle(1);
    end
    peek(2'd0, s); chk("R2 status settles", {24'h0, s}, 32'h30);
    chk("R2 count cleared", {24'h0, mbxCount}, 32'h0);
    chk("R2 base cleared", mbxBase, 32'h0);
    chk("R2 ext cleared", {31'h0, extMode}, 32'h0);
    chk("R2 wide cleared", {31'h0, wideMode}, 32'h0);

    // R11 full opcode sweep
    for (int op = 0; op < 256; op++) begin
      bit known;
      known = (op == 8'h01) || (op == 8'h02) || (op == 8'h04) || (op == 8'h0B) ||
              (op == 8'h81) || (op == 8'h8D) || (op == 8'h96);
      hardReset();
      sendByte(8'(op));
      peek(2'd0, s);
      if (known) chk("R11 known opcode not invalid", {31'h0, s[0]}, 32'h0);
      else begin
        chk("R11 invalid status", {24'h0, s}, 32'h21);
        peek(2'd2, s); chk("R11 invalid intr", {24'h0, s}, 32'h84);
        sendByte(8'h04);
        idle(2);
        peek(2'd0, s); chk("R11 opcode ignored in lockout", {24'h0, s}, 32'h21);
      end
    end

    // R10 start accepted during lockout; R13 soft reset keeps lockout
    hardReset();
    sendByte(8'h42);
    hostWrite(2'd0, 8'h20);
    hostWrite(2'd1, 8'h02);
    chk("R10 start during lockout", {31'h0, mbxStart}, 32'h1);
    idle(1);
    peek(2'd2, s); chk("R10 lockout start no complete", {24'h0, s}, 32'h00);
    hostWrite(2'd0, 8'h40);
    peek(2'd0, s); chk("R13 soft keeps lockout", {24'h0, s}, 32'h21);
    hardReset();
    peek(2'd0, s); chk("R11 hard reset recovers", {24'h0, s}, 32'h30);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

endmodule